// File: doc/BRIEF.md
# Programmable Clock Root Slice

This block produces one root clock from a single 32-bit control word. The word holds four fields: an output enable, a three-bit choice among eight source clocks, a pre-divider of 1 to 8 and a post-divider of 1 to 64. The selected source is divided by the pre-divider, and that result is divided by the post-divider. The final clock is then gated by the enable. Each divider field holds its divide value minus one, so an all-zero word means gate off, source 0 and no division.

Every source is a square wave that is synchronous to, and at most half the rate of, the block's system clock. The divided output is a registered level in that system clock domain. All three kinds of change are made without runt pulses. A source change first parks the output low, then restarts both dividers on the first rising edge of the new source. A divider value is taken up only at the start of that divider's own period. The enable takes effect only while the divided clock is low. A status word reports the settings currently in force. It uses the same bit layout as the control word.

Top module: `ckr_root_slice`

## Requirements
- R1: Field positions of the control word: bit 28 is the output enable, bits 26:24 are the source index (0 to 7), bits 18:16 are the pre-divide value minus one, and bits 5:0 are the post-divide value minus one. All other bits ignore writes and read as zero.
- R2: A read returns the last written word, with the bits outside the R1 fields cleared, from the cycle after the write.
- R3: After reset the control word and the status word are zero, and the output clock stays low.
- R4: Once settled, the output period equals 2*(half-period of the selected source)*pre*post system cycles, where pre and post are the divide values.
- R5: A divider stage with divide value 1 passes its input unchanged. A stage with divide value N>1 holds its output high for floor(N/2) input cycles and low for the remaining ceil(N/2).
- R6: While the applied enable is 0 the output clock is low. A change of the enable is applied only while the divided clock is low, so a high phase that is already under way completes in full.
- R7: On a source change the output stops at a low level. The applied source index changes only while the output is low. Output resumes after a rising edge of the new source, and every high phase during the change has the full length of either the old or the new setting.
- R8: A new divider value is applied only at the start of that stage's period, so every output period during the change equals either the old or the new period.
- R9: The status output reports the applied enable, source, pre-divide and post-divide in the R1 layout, and once settled it equals the written word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the control word |
| wr_data_i | input | 32 | Control word to write |
| rd_data_o | output | 32 | Control word read-back |
| src_clk_i | input | 8 | Source clocks, synchronous square waves |
| clk_o | output | 1 | Gated, divided root clock |
| applied_o | output | 32 | Settings in force, in control word layout |

## Verification
The assertions assume that every source clock is a clean level that changes only on system clock edges. They also assume that every source keeps toggling, since a stalled source would hold off both the drain and the resynchronisation. The bench generates source k as a square wave with a half-period of k+1 system cycles and changes it only on falling system clock edges. As a result, every source is free-running and the selected one always delivers a rising edge. Writes are single-cycle strobes applied away from the active edge. The window checks that watch a transition therefore always see whole periods of the old and new settings.

// File: rtl/ckr_pkg.sv
package ckr_pkg;

    localparam int CKR_WORD_W   = 32;
    localparam int CKR_SEL_W    = 3;
    localparam int CKR_PRE_W    = 3;
    localparam int CKR_POST_W   = 6;
    localparam int CKR_GATE_BIT = 28;
    localparam int CKR_SRC_LSB  = 24;
    localparam int CKR_PRE_LSB  = 16;
    localparam int CKR_POST_LSB = 0;
    localparam int CKR_NUM_SRC  = 1 << CKR_SEL_W;

    localparam logic [CKR_WORD_W-1:0] CKR_CFG_MASK =
        (32'h1 << CKR_GATE_BIT)
      | (((32'h1 << CKR_SEL_W)  - 32'h1) << CKR_SRC_LSB)
      | (((32'h1 << CKR_PRE_W)  - 32'h1) << CKR_PRE_LSB)
      | (((32'h1 << CKR_POST_W) - 32'h1) << CKR_POST_LSB);

    typedef struct packed {
        logic                  gate;
        logic [CKR_SEL_W-1:0]  src;
        logic [CKR_PRE_W-1:0]  pre;
        logic [CKR_POST_W-1:0] post;
    } ckr_cfg_t;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_DRAIN = 2'd1,
        SW_SYNC  = 2'd2
    } ckr_sw_state_e;

    function automatic ckr_cfg_t ckr_unpack(input logic [CKR_WORD_W-1:0] w);
        ckr_cfg_t c;
        c.gate = w[CKR_GATE_BIT];
        c.src  = w[CKR_SRC_LSB  +: CKR_SEL_W];
        c.pre  = w[CKR_PRE_LSB  +: CKR_PRE_W];
        c.post = w[CKR_POST_LSB +: CKR_POST_W];
        return c;
    endfunction

    function automatic logic [CKR_WORD_W-1:0] ckr_pack(input ckr_cfg_t c);
        logic [CKR_WORD_W-1:0] w;
        w = '0;
        w[CKR_GATE_BIT]                = c.gate;
        w[CKR_SRC_LSB  +: CKR_SEL_W]  = c.src;
        w[CKR_PRE_LSB  +: CKR_PRE_W]  = c.pre;
        w[CKR_POST_LSB +: CKR_POST_W] = c.post;
        return w;
    endfunction

endpackage

// File: rtl/ckr_div_stage.sv
// One integer divider stage. The ratio is stored as divide value minus one.
// Ratio 0 passes the input level through (registered). A new ratio is
// accepted only on the input rising edge that opens a period.
module ckr_div_stage #(
    parameter int W = 3
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         restart_i,
    input  logic         in_i,
    input  logic [W-1:0] ratio_req_i,
    output logic [W-1:0] ratio_o,
    output logic         out_o
);

    typedef struct packed {
        logic         prev;
        logic         started;
        logic [W-1:0] cnt;
        logic [W-1:0] ratio;
        logic         level;
    } div_st_t;

    div_st_t q, d;

    logic         rise;
    logic         wrap;
    logic [W-1:0] eff;
    logic [W-1:0] pos;
    logic [W:0]   half;

    always_comb begin
        d    = q;
        rise = in_i & ~q.prev;
        wrap = ~q.started | (q.cnt == q.ratio);
        eff  = (rise && wrap) ? ratio_req_i : q.ratio;
        pos  = (rise && !wrap) ? q.cnt + W'(1) : '0;
        half = ({1'b0, eff} + (W+1)'(1)) >> 1;

        d.prev = in_i;
        if (restart_i) begin
            // wait for a fresh rising edge: pretend the input was high
            d.prev    = 1'b1;
            d.started = 1'b0;
            d.cnt     = '0;
            d.level   = 1'b0;
        end else begin
            if (rise) begin
                d.started = 1'b1;
                d.cnt     = pos;
                if (wrap) begin
                    d.ratio = ratio_req_i;
                end
            end
            if (eff == '0) begin
                d.level = in_i & (q.started | rise);
            end else if (rise) begin
                d.level = ({1'b0, pos} < half);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ratio_o = q.ratio;
    assign out_o   = q.level;

endmodule

// File: rtl/ckr_src_switch.sv
// Source selector with drain / resynchronise sequencing.
module ckr_src_switch #(
    parameter int NUM_SRC = 8,
    parameter int SEL_W   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_SRC-1:0] src_clk_i,
    input  logic [SEL_W-1:0]  sel_req_i,
    input  logic              stage_level_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic              sel_clk_o,
    output logic              restart_o,
    output logic              hold_o
);
    import ckr_pkg::*;

    typedef struct packed {
        ckr_sw_state_e    state;
        logic [SEL_W-1:0] sel;
        logic             prev;
        logic             hold;
    } sw_st_t;

    sw_st_t q, d;
    logic   rise;

    always_comb begin
        d         = q;
        restart_o = 1'b0;
        sel_clk_o = src_clk_i[q.sel];
        rise      = sel_clk_o & ~q.prev;
        d.prev    = sel_clk_o;

        unique case (q.state)
            SW_RUN: begin
                if (sel_req_i != q.sel) begin
                    d.state = SW_DRAIN;
                end
            end
            SW_DRAIN: begin
                // park only once the divided clock is low
                if (!stage_level_i) begin
                    d.hold    = 1'b1;
                    d.sel     = sel_req_i;
                    d.prev    = 1'b1;
                    restart_o = 1'b1;
                    d.state   = SW_SYNC;
                end
            end
            SW_SYNC: begin
                if (rise) begin
                    d.hold  = 1'b0;
                    d.state = SW_RUN;
                end
            end
            default: begin
                d.state = SW_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sel_o  = q.sel;
    assign hold_o = q.hold;

endmodule

// File: rtl/ckr_root_slice.sv
module ckr_root_slice
    import ckr_pkg::*;
(
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   wr_en_i,
    input  logic [CKR_WORD_W-1:0]  wr_data_i,
    output logic [CKR_WORD_W-1:0]  rd_data_o,
    input  logic [CKR_NUM_SRC-1:0] src_clk_i,
    output logic                   clk_o,
    output logic [CKR_WORD_W-1:0]  applied_o
);

    typedef struct packed {
        logic [CKR_WORD_W-1:0] cfg;
        logic                  gate;
        logic                  clk;
    } top_st_t;

    top_st_t q, d;

    ckr_cfg_t              req;
    ckr_cfg_t              now;
    logic [CKR_SEL_W-1:0]  sel_applied;
    logic [CKR_PRE_W-1:0]  pre_applied;
    logic [CKR_POST_W-1:0] post_applied;
    logic                  sel_clk;
    logic                  restart;
    logic                  hold;
    logic                  pre_level;
    logic                  post_level;

    always_comb begin
        d   = q;
        req = ckr_unpack(q.cfg);
        if (wr_en_i) begin
            d.cfg = wr_data_i & CKR_CFG_MASK;
        end
        // enable changes only while the divided clock is low
        if (!post_level) begin
            d.gate = req.gate;
        end
        d.clk = q.gate & ~hold & post_level;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    ckr_src_switch #(
        .NUM_SRC (CKR_NUM_SRC),
        .SEL_W   (CKR_SEL_W)
    ) u_switch (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .src_clk_i     (src_clk_i),
        .sel_req_i     (req.src),
        .stage_level_i (post_level),
        .sel_o         (sel_applied),
        .sel_clk_o     (sel_clk),
        .restart_o     (restart),
        .hold_o        (hold)
    );

    ckr_div_stage #(.W(CKR_PRE_W)) u_pre (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .restart_i   (restart),
        .in_i        (sel_clk),
        .ratio_req_i (req.pre),
        .ratio_o     (pre_applied),
        .out_o       (pre_level)
    );

    ckr_div_stage #(.W(CKR_POST_W)) u_post (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .restart_i   (restart),
        .in_i        (pre_level),
        .ratio_req_i (req.post),
        .ratio_o     (post_applied),
        .out_o       (post_level)
    );

    always_comb begin
        now.gate = q.gate;
        now.src  = sel_applied;
        now.pre  = pre_applied;
        now.post = post_applied;
    end

    assign rd_data_o = q.cfg;
    assign clk_o     = q.clk;
    assign applied_o = ckr_pack(now);

endmodule

// File: rtl/ckr_root_slice_chk.sv
module ckr_root_slice_chk
    import ckr_pkg::*;
(
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  wr_en_i,
    input logic [CKR_WORD_W-1:0] wr_data_i,
    input logic [CKR_WORD_W-1:0] rd_data_o,
    input logic                  clk_o,
    input logic [CKR_WORD_W-1:0] applied_o
);

    // R2
    readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_en_i |=> (rd_data_o == ($past(wr_data_i) & CKR_CFG_MASK)));

    // R6
    gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !applied_o[CKR_GATE_BIT] |=> !clk_o);

    // R6
    rise_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(clk_o) |-> $past(applied_o[CKR_GATE_BIT]));

    // R7
    src_switch_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(applied_o[CKR_SRC_LSB +: CKR_SEL_W]) |-> !clk_o);

endmodule

bind ckr_root_slice ckr_root_slice_chk chk_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .clk_o     (clk_o),
    .applied_o (applied_o)
);

// File: tb/ckr_root_slice_tb.sv
module ckr_root_slice_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LIMIT      = 20000;
    localparam int NVEC       = 10;
    // src, pre, post, expected period, expected high time (system cycles)
    localparam int VEC [NVEC][5] = '{
        '{0, 1,  1,    2,    1},
        '{1, 1,  1,    4,    2},
        '{2, 3,  1,   18,    6},
        '{3, 2,  5,   80,   32},
        '{5, 1,  4,   48,   24},
        '{4, 5,  3,  150,   50},
        '{6, 1,  2,   28,   14},
        '{7, 8, 64, 8192, 4096},
        '{0, 8,  1,   16,    8},
        '{0, 1,  7,   14,    6}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [31:0] wr_data;
    logic [31:0] rd_data;
    logic [7:0]  src_clk;
    logic        clk_o;
    logic [31:0] applied;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;
    bit  last_s = 1'b0;
    bit  rise_s = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ckr_root_slice dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .rd_data_o (rd_data),
        .src_clk_i (src_clk),
        .clk_o     (clk_o),
        .applied_o (applied)
    );

    // source k: square wave with a half-period of k+1 system cycles
    initial begin
        int cnt [8];
        src_clk = '0;
        for (int k = 0; k < 8; k++) cnt[k] = 0;
        forever begin
            @(negedge clk);
            for (int k = 0; k < 8; k++) begin
                if (cnt[k] == k) begin
                    src_clk[k] = ~src_clk[k];
                    cnt[k] = 0;
                end else begin
                    cnt[k] = cnt[k] + 1;
                end
            end
        end
    end

    function automatic logic [31:0] mk(input int g, input int s, input int pr, input int po);
        return (32'(g) << 28) | (32'(s) << 24) | (32'(pr - 1) << 16) | 32'(po - 1);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        rise_s = clk_o && !last_s;
        last_s = clk_o;
    endtask

    task automatic write(input logic [31:0] w);
        wr_en   = 1'b1;
        wr_data = w;
        tick();
        wr_en   = 1'b0;
    endtask

    task automatic wait_rise(output int n);
        n = 0;
        do begin
            tick();
            n++;
        end while (!rise_s && n < LIMIT);
        if (!rise_s) n = -1;
    endtask

    // current sample is a rise; run to the next rise
    task automatic from_rise(output int per, output int hi);
        hi  = 1;
        per = 0;
        forever begin
            tick();
            per++;
            if (rise_s) break;
            if (clk_o) hi++;
            if (per > LIMIT) begin
                per = -1;
                break;
            end
        end
    endtask

    task automatic measure(output int per, output int hi);
        int n;
        wait_rise(n);
        if (n < 0) begin
            per = -1;
            hi  = -1;
        end else begin
            from_rise(per, hi);
        end
    endtask

    // every period in the window must be whole: old or new shape
    task automatic watch(input int cnt, input int pa, input int ha,
                         input int pb, input int hb, input bit chk_per, input string tag);
        int n, per, hi;
        wait_rise(n);
        check(n > 0, tag, n, 1);
        for (int i = 0; i < cnt; i++) begin
            from_rise(per, hi);
            check(hi == ha || hi == hb, tag, hi, hb);
            if (chk_per) check(per == pa || per == pb, tag, per, pb);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R4 watchdog expired act=0 exp=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int per, hi, n, highs;
        logic [31:0] w;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_data = '0;
        repeat (5) tick();
        rst_n = 1'b1;

        // R3: reset state
        check(rd_data == 32'h0, "R3 reset word", rd_data, 0);
        check(applied == 32'h0, "R3 reset status", applied, 0);
        highs = 0;
        repeat (40) begin
            tick();
            if (clk_o) highs++;
        end
        check(highs == 0, "R3 output low after reset", highs, 0);

        // R1/R2: field positions and unused bits
        write(32'hFFFF_FFFF);
        check(rd_data == 32'h1707_003F, "R1 all-ones readback", rd_data, 32'h1707_003F);
        write(32'hE8F8_FFC0);
        check(rd_data == 32'h0, "R1 unused bits ignored", rd_data, 0);
        write(32'h0000_0000);

        // R4/R5/R9: vector table
        for (int v = 0; v < NVEC; v++) begin
            w = mk(1, VEC[v][0], VEC[v][1], VEC[v][2]);
            write(w);
            check(rd_data == w, "R2 readback", rd_data, w);
            for (int i = 0; i < 4; i++) wait_rise(n);
            measure(per, hi);
            check(per == VEC[v][3], "R4 period", per, VEC[v][3]);
            check(hi == VEC[v][4], "R5 high time", hi, VEC[v][4]);
            check(applied == w, "R9 applied status", applied, w);
        end

        // R6: gate off during a high phase; that phase completes in full
        wait_rise(n);
        wr_en   = 1'b1;
        wr_data = mk(0, 0, 1, 7);
        tick();
        wr_en = 1'b0;
        highs = 1;
        while (clk_o && highs < 100) begin
            highs++;
            tick();
        end
        check(highs == 6, "R6 high phase completes", highs, 6);
        highs = 0;
        repeat (100) begin
            tick();
            if (clk_o) highs++;
        end
        check(highs == 0, "R6 output held low", highs, 0);
        check(applied[28] == 1'b0, "R6 applied gate off", applied[28], 0);
        write(mk(1, 0, 1, 7));
        for (int i = 0; i < 2; i++) wait_rise(n);
        measure(per, hi);
        check(per == 14 && hi == 6, "R6 gate re-enabled", per, 14);

        // R7: source switch, whole phases only
        write(mk(1, 1, 2, 3));
        for (int i = 0; i < 4; i++) wait_rise(n);
        measure(per, hi);
        check(per == 24 && hi == 8, "R7 old source shape", per, 24);
        write(mk(1, 3, 2, 3));
        watch(6, 24, 8, 48, 16, 1'b0, "R7 switch pulse");
        measure(per, hi);
        check(per == 48 && hi == 16, "R7 new source shape", per, 48);

        // R8: divider change at period boundary
        write(mk(1, 0, 2, 3));
        for (int i = 0; i < 4; i++) wait_rise(n);
        measure(per, hi);
        check(per == 12 && hi == 4, "R8 old divider shape", per, 12);
        write(mk(1, 0, 2, 5));
        watch(6, 12, 4, 20, 8, 1'b1, "R8 divider change");
        check(applied == mk(1, 0, 2, 5), "R9 applied after divider change", applied, mk(1, 0, 2, 5));

        // R3: reset while running
        rst_n = 1'b0;
        tick();
        check(rd_data == 32'h0 && applied == 32'h0, "R3 mid-run reset", rd_data, 0);
        rst_n = 1'b1;
        highs = 0;
        repeat (60) begin
            tick();
            if (clk_o) highs++;
        end
        check(highs == 0, "R3 output low after mid-run reset", highs, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule